// File: doc/BRIEF.md
# Receive Byte Decimation Sampler

This block sits on the receive side of a serial gigabit link, after the line decoder. The decoder delivers a data valid flag, an error flag and a data byte on every cycle of a 125 MHz clock. When the port runs at 100 Mb/s or 10 Mb/s, the far end has repeated each original byte 10 or 100 times to fill that clock. The sampler undoes the repetition. It emits one strobe for each original byte, together with the byte and its error flag. The replication factor comes from a two-bit speed code, which is recovered from the link control word exchange.

Sampling is not tied to any free-running boundary, because the stream has none. The cycle in which data valid rises is taken as position zero of the frame. Every byte is then sampled in the middle of its own repetition window. The far end may repeat the first byte one time fewer than normal, and this midpoint placement keeps every sample inside the right byte in that case too. Carrier sense is taken from data valid before decimation. Collision is reported when carrier sense and the local transmit enable are high together.

Top module: `rate_decimator`

## Requirements
- R1: The repetition factor N follows the latched speed code: code 2'b10 gives N=1 (a sample every cycle), 2'b01 gives N=10, 2'b00 gives N=100, and the reserved code 2'b11 is handled like 2'b10.
- R2: The cycle in which inValid rises is frame position 0. Byte k is sampled at position k*N + N/2 (integer division), and the strobe, byte and error flag for that sample appear on the outputs one cycle later.
- R3: If the first byte of a frame is repeated only N-1 times, every byte of the frame is still delivered with the correct value, at the positions given in R2.
- R4: sampleStb is high for exactly one cycle per delivered byte, and only while outValid is high. outData and outErr keep their values between strobes.
- R5: outErr carries the value that inErr had in the sample cycle of that byte.
- R6: At the first sample position at which inValid is low, outValid falls one cycle later and no strobe is issued. Nothing further is sampled until the next rising edge of inValid.
- R7: crs equals inValid in the same cycle, with no register in between.
- R8: col equals inValid AND txEnable in the same cycle.
- R9: speedSel is taken in only while inValid is low and no frame is waiting for its closing sample. A change of speedSel during a frame does not alter that frame's sample positions.
- R10: While reset is held and directly after it, sampleStb, outValid and outErr are 0 and outData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speedSel | input | 2 | Speed code: 10 = 1000 Mb/s, 01 = 100 Mb/s, 00 = 10 Mb/s, 11 = reserved (treated as 1000 Mb/s) |
| inValid | input | 1 | Decoded data valid, replicated stream |
| inErr | input | 1 | Decoded error flag, replicated stream |
| inData | input | DATA_W | Decoded data byte, replicated stream |
| txEnable | input | 1 | Local transmit enable, used for collision |
| sampleStb | output | 1 | One-cycle strobe marking a new decimated byte |
| outValid | output | 1 | Decimated data valid |
| outErr | output | 1 | Error flag of the decimated byte |
| outData | output | DATA_W | Decimated data byte |
| crs | output | 1 | Carrier sense, taken from inValid before decimation |
| col | output | 1 | Collision: carrier sense and transmit enable both high |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, N=10 for the middle rate and N=100 for the low rate. With these values the sample counter runs through its full range, and frames at all three rates, including the longest 100-cycle windows, fit well inside the run. Frames at every speed code are checked for strobe timing against the frame start, with full and shortened first bytes, with errors on chosen bytes and with speed changes in the middle of a frame. Each frame is checked for the exact cycle in which outValid falls.

// File: rtl/rate_dec_pkg.sv
package rate_dec_pkg;

  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10,
    SPD_RSVD = 2'b11
  } speedCode_e;

  // Strobes from the sequencer to the capture path
  typedef struct packed {
    logic frameStart;
    logic samplePt;
  } decStrobe_t;

endpackage

// File: rtl/rate_dec_ctl.sv
module rate_dec_ctl
  import rate_dec_pkg::*;
#(
  parameter int REP_MID = 10,
  parameter int REP_LOW = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] speedSel,
  input  logic       inValid,
  output decStrobe_t stb
);

  localparam int CNT_W = $clog2(REP_LOW + 1);
  localparam logic [CNT_W-1:0] LEN_MID  = CNT_W'(REP_MID);
  localparam logic [CNT_W-1:0] LEN_LOW  = CNT_W'(REP_LOW);
  localparam logic [CNT_W-1:0] LEN_FULL = CNT_W'(1);

  speedCode_e       activeSpeed;
  logic             prevValid;
  logic             inFrame;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] curCnt;
  logic [CNT_W-1:0] repLen;
  logic [CNT_W-1:0] midPt;
  logic             frameStart;
  logic             samplePt;
  logic             wrapNow;

  always_comb begin
    case (activeSpeed)
      SPD_100: repLen = LEN_MID;
      SPD_10:  repLen = LEN_LOW;
      default: repLen = LEN_FULL;
    endcase
    midPt      = repLen >> 1;
    frameStart = inValid & ~prevValid;
    curCnt     = frameStart ? '0 : cnt;
    wrapNow    = (curCnt >= repLen - CNT_W'(1));
    samplePt   = (frameStart | inFrame) & (curCnt == midPt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeSpeed <= SPD_1000;
      prevValid   <= 1'b0;
      inFrame     <= 1'b0;
      cnt         <= '0;
    end else begin
      prevValid <= inValid;
      if (!inValid && !inFrame) activeSpeed <= speedCode_e'(speedSel);
      cnt <= wrapNow ? '0 : curCnt + CNT_W'(1);
      if (samplePt && !inValid) inFrame <= 1'b0;
      else if (frameStart)      inFrame <= 1'b1;
    end
  end

  assign stb.frameStart = frameStart;
  assign stb.samplePt   = samplePt;

  // R9: rate frozen during a frame and its tail
  a_r9_speed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid || inFrame) |=> $stable(activeSpeed));

  // R1: below full rate, two sample points are never adjacent
  a_r1_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (samplePt && repLen != LEN_FULL) |=> !samplePt);

  // R2: the counter restarts at the frame start
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (frameStart && repLen != LEN_FULL) |=> (cnt == CNT_W'(1)));

endmodule

// File: rtl/rate_dec_dp.sv
module rate_dec_dp
  import rate_dec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  decStrobe_t        stb,
  input  logic              inValid,
  input  logic              inErr,
  input  logic [DATA_W-1:0] inData,
  output logic              sampleStb,
  output logic              outValid,
  output logic              outErr,
  output logic [DATA_W-1:0] outData
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sampleStb <= 1'b0;
      outValid  <= 1'b0;
      outErr    <= 1'b0;
      outData   <= '0;
    end else begin
      sampleStb <= stb.samplePt & inValid;
      if (stb.samplePt) outValid <= inValid;
      if (stb.samplePt && inValid) begin
        outData <= inData;
        outErr  <= inErr;
      end
    end
  end

  // R4: a strobe only accompanies valid data
  a_r4_strobe_valid: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStb |-> outValid);

  // R5 / R4: byte and error hold between sample points
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.samplePt |=> ($stable(outData) && $stable(outErr)));

  // R6: the closing sample carries no strobe
  a_r6_close_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(outValid) |-> !sampleStb);

  // R2: a frame start is always seen with valid high
  a_r2_start_valid: assert property (@(posedge clk) disable iff (!rst_n)
    stb.frameStart |-> inValid);

endmodule

// File: rtl/rate_decimator.sv
module rate_decimator
  import rate_dec_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int REP_MID = 10,
  parameter int REP_LOW = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        speedSel,
  input  logic              inValid,
  input  logic              inErr,
  input  logic [DATA_W-1:0] inData,
  input  logic              txEnable,
  output logic              sampleStb,
  output logic              outValid,
  output logic              outErr,
  output logic [DATA_W-1:0] outData,
  output logic              crs,
  output logic              col
);

  decStrobe_t decStb;

  rate_dec_ctl #(.REP_MID(REP_MID), .REP_LOW(REP_LOW)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .speedSel (speedSel),
    .inValid  (inValid),
    .stb      (decStb)
  );

  rate_dec_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (decStb),
    .inValid   (inValid),
    .inErr     (inErr),
    .inData    (inData),
    .sampleStb (sampleStb),
    .outValid  (outValid),
    .outErr    (outErr),
    .outData   (outData)
  );

  // R7 / R8: carrier and collision come from the undecimated valid
  assign crs = inValid;
  assign col = inValid & txEnable;

  // R8: collision never without carrier
  a_r8_col_needs_crs: assert property (@(posedge clk) disable iff (!rst_n)
    col |-> crs);

endmodule

// File: tb/rate_decimator_test.sv
`timescale 1ns/1ps
module rate_decimator_test;

  localparam int DATA_W  = 8;
  localparam int REP_MID = 10;
  localparam int REP_LOW = 100;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        speedSel = 2'b10;
  logic              inValid = 1'b0;
  logic              inErr = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic              txEnable = 1'b0;
  logic              sampleStb, outValid, outErr, crs, col;
  logic [DATA_W-1:0] outData;

  rate_decimator #(.DATA_W(DATA_W), .REP_MID(REP_MID), .REP_LOW(REP_LOW)) uut (
    .clk(clk), .rst_n(rst_n), .speedSel(speedSel), .inValid(inValid),
    .inErr(inErr), .inData(inData), .txEnable(txEnable),
    .sampleStb(sampleStb), .outValid(outValid), .outErr(outErr),
    .outData(outData), .crs(crs), .col(col)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int stbCyc[$];
  int stbDat[$];
  int stbErr[$];
  int fallCyc = -1;
  bit prevOV = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int repFor(input logic [1:0] spd);
    case (spd)
      2'b01:   return REP_MID;
      2'b00:   return REP_LOW;
      default: return 1;
    endcase
  endfunction

  // Monitor: just after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (sampleStb) begin
        stbCyc.push_back(cyc);
        stbDat.push_back(int'(outData));
        stbErr.push_back(int'(outErr));
      end
      if (prevOV && !outValid) fallCyc = cyc;
      prevOV = outValid;
      chk(crs == inValid, "R7", "crs", int'(crs), int'(inValid));
      chk(col == (inValid & txEnable), "R8", "col", int'(col),
          int'(inValid & txEnable));
    end
  end

  task automatic runFrame(input logic [1:0] spd, input int nb,
                          input bit shortReq, input int errIdx,
                          input bit chgSpd);
    int n, mid, startC, reps;
    bit shortFirst;
    logic [DATA_W-1:0] dat[8];
    n = repFor(spd);
    mid = n / 2;
    shortFirst = shortReq && (n > 1);
    for (int i = 0; i < nb; i++) dat[i] = DATA_W'($urandom);
    @(negedge clk);
    speedSel = spd;
    inValid = 1'b0;
    repeat (3) begin
      txEnable = 1'($urandom);
      @(negedge clk);
    end
    stbCyc.delete(); stbDat.delete(); stbErr.delete();
    fallCyc = -1;
    startC = cyc;
    for (int k = 0; k < nb; k++) begin
      reps = (k == 0 && shortFirst) ? n - 1 : n;
      for (int r = 0; r < reps; r++) begin
        inValid = 1'b1;
        inData = dat[k];
        inErr = (k == errIdx);
        txEnable = 1'($urandom);
        if (chgSpd && k == 1 && r == 0) speedSel = (spd == 2'b01) ? 2'b00 : 2'b01;
        @(negedge clk);
      end
    end
    inValid = 1'b0;
    inErr = 1'b0;
    inData = DATA_W'($urandom);
    repeat (n + 4) begin
      txEnable = 1'($urandom);
      @(negedge clk);
    end
    // R1 / R9: one strobe per byte at the frame's own rate
    chk(stbCyc.size() == nb, chgSpd ? "R9" : "R1", "strobe count",
        stbCyc.size(), nb);
    for (int k = 0; k < nb && k < stbCyc.size(); k++) begin
      chk(stbCyc[k] == startC + k * n + mid + 1, chgSpd ? "R9" : "R2",
          "strobe cycle", stbCyc[k] - startC, k * n + mid + 1);
      chk(stbDat[k] == int'(dat[k]), shortFirst ? "R3" : "R2", "byte",
          stbDat[k], int'(dat[k]));
      chk(stbErr[k] == int'(k == errIdx), "R5", "err flag", stbErr[k],
          int'(k == errIdx));
    end
    chk(fallCyc == startC + nb * n + mid + 1, "R6", "valid fall cycle",
        fallCyc - startC, nb * n + mid + 1);
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (4) @(negedge clk);
    // R10: outputs cleared by reset
    chk(sampleStb == 1'b0, "R10", "sampleStb", int'(sampleStb), 0);
    chk(outValid == 1'b0, "R10", "outValid", int'(outValid), 0);
    chk(outErr == 1'b0, "R10", "outErr", int'(outErr), 0);
    chk(outData == '0, "R10", "outData", int'(outData), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0 && sampleStb == 1'b0, "R10", "after release",
        int'(outValid), 0);

    runFrame(2'b10, 4, 1'b0, -1, 1'b0);  // R1 gigabit
    runFrame(2'b01, 3, 1'b0, 1, 1'b0);   // R1 100, error on byte 1
    runFrame(2'b01, 4, 1'b1, -1, 1'b0);  // R3 shortened first byte
    runFrame(2'b00, 2, 1'b1, 0, 1'b0);   // R3 R5 10 Mb/s
    runFrame(2'b11, 3, 1'b0, 2, 1'b0);   // R1 reserved code
    runFrame(2'b01, 3, 1'b0, -1, 1'b1);  // R9 change mid-frame
    runFrame(2'b10, 1, 1'b0, 0, 1'b1);   // R9 at gigabit
    runFrame(2'b10, 1, 1'b0, -1, 1'b0);  // single-byte frame

    for (int f = 0; f < 30; f++) begin
      logic [1:0] spd;
      int nb, eIdx;
      spd = 2'($urandom_range(0, 3));
      nb = (spd == 2'b00) ? int'($urandom_range(1, 3)) : int'($urandom_range(1, 6));
      eIdx = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, nb - 1)) : -1;
      runFrame(spd, nb, 1'($urandom), eIdx, ($urandom_range(0, 4) == 0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule